// File: doc/BRIEF.md
# Inverse Page Table Translator

This block turns a logical RAM address into a physical address through a table that holds one entry per physical page. Each entry names the logical page that currently sits on its physical page and carries a two-bit protection level. On every access the logical page number is compared with all entries at once. The index of the matching entry becomes the upper part of the physical address, and the in-page offset passes through unchanged.

The page size can be selected as 4, 8, 16 or 32 KB. This moves the boundary between the page-number bits and the offset bits. The privilege mode and the access direction are checked against the protection level of the matching entry. An access that finds no entry, or that is not allowed, raises an abort in the same cycle. Software-side setup goes through a write port that loads one entry per clock. Reset marks every entry invalid.

Top module: `inv_page_xlate`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses until an entry is written.
- R2: The page number of a lookup is `la >> (MIN_OFF + page_sz)`, where `page_sz` encodes 0 = 4 KB, 1 = 8 KB, 2 = 16 KB and 3 = 32 KB (for the default `MIN_OFF` of 12). An entry hits when it is valid and its stored logical page equals this number.
- R3: On a hit, `pa` equals the entry index shifted left by `MIN_OFF + page_sz`, ORed with the low `MIN_OFF + page_sz` bits of `la`. On a miss, `pa` is zero.
- R4: When several valid entries hold the same logical page, the lowest-numbered one supplies `pa` and the protection level.
- R5: A lookup with `req` high that matches no entry gives `hit` low and `abort` high.
- R6: Supervisor mode (`mode` 2 or 3) never aborts on a hit.
- R7: User mode (`mode` 0) may read and write at level 0, may only read at level 1, and aborts on any access at levels 2 and 3.
- R8: OS mode (`mode` 1) may read and write at levels 0 and 1, and may only read at levels 2 and 3. `wr` high marks a write.
- R9: An entry loaded with `wen` high takes part in lookups from the next clock edge and replaces that index's earlier page and level.
- R10: With `req` low, `abort` stays low whatever the lookup result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; invalidates all entries |
| req | input | 1 | Access in progress; gates abort |
| wr | input | 1 | 1 = write access, 0 = read |
| mode | input | 2 | 0 user, 1 OS, 2 or 3 supervisor |
| page_sz | input | 2 | Page size select |
| la | input | LPN_W+MIN_OFF | Logical address |
| wen | input | 1 | Load an entry at the clock edge |
| widx | input | $clog2(ENTRIES) | Entry (physical page) to load |
| wlpn | input | LPN_W | Logical page for the entry |
| wprot | input | 2 | Protection level for the entry |
| pa | output | $clog2(ENTRIES)+MIN_OFF+3 | Physical address |
| hit | output | 1 | Some valid entry matched |
| abort | output | 1 | Miss or protection violation while req is high |

## Verification
On every cycle the assertions check the abort rules: no abort while idle, an abort on every requested miss, none for supervisor hits or OS reads. They also check that the offset bits pass through to the physical address, and that nothing hits straight after reset. The choice of entry when several match, the exact index in the upper address bits, and the user and OS permission tables per level can only be shown by the bench. It programs a small table with duplicates and every level, then sweeps every address, page size, mode and direction against a model of its own.

// File: rtl/inv_page_xlate.sv
module inv_page_xlate #(
  parameter int ENTRIES = 128,
  parameter int LPN_W   = 13,
  parameter int MIN_OFF = 12,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int LA_W   = LPN_W + MIN_OFF,
  localparam int PA_W   = IDX_W + MIN_OFF + 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             wr,
  input  logic [1:0]       mode,
  input  logic [1:0]       page_sz,
  input  logic [LA_W-1:0]  la,
  input  logic             wen,
  input  logic [IDX_W-1:0] widx,
  input  logic [LPN_W-1:0] wlpn,
  input  logic [1:0]       wprot,
  output logic [PA_W-1:0]  pa,
  output logic             hit,
  output logic             abort
);

  logic [ENTRIES-1:0] vld;
  logic [LPN_W-1:0]   lpn_q  [ENTRIES];
  logic [1:0]         prot_q [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld <= '0;
    else if (wen) vld[widx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wen) begin
      lpn_q[widx]  <= wlpn;
      prot_q[widx] <= wprot;
    end
  end

  logic [4:0]      shamt;
  logic [LA_W-1:0] pg;
  logic [LA_W-1:0] off;

  assign shamt = 5'(MIN_OFF) + {3'b0, page_sz};
  assign pg    = la >> shamt;
  assign off   = la & ((LA_W'(1) << shamt) - LA_W'(1));

  logic [ENTRIES-1:0] match;
  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign match[i] = vld[i] && (lpn_q[i] == pg[LPN_W-1:0]);
  end

  logic [IDX_W-1:0] sel;
  always_comb begin
    sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (match[i]) sel = IDX_W'(i);
  end

  logic [1:0] lvl;
  logic       permit;
  assign lvl = prot_q[sel];

  always_comb begin
    case (mode)
      2'd0:    permit = (lvl == 2'd0) || (lvl == 2'd1 && !wr);
      2'd1:    permit = !lvl[1] || !wr;
      default: permit = 1'b1;
    endcase
  end

  assign hit   = |match;
  assign pa    = hit ? ((PA_W'(sel) << shamt) | PA_W'(off)) : '0;
  assign abort = req && (!hit || !permit);

endmodule

module inv_page_xlate_chk #(
  parameter int ENTRIES = 128,
  parameter int LPN_W   = 13,
  parameter int MIN_OFF = 12,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int LA_W   = LPN_W + MIN_OFF,
  localparam int PA_W   = IDX_W + MIN_OFF + 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req,
  input logic            wr,
  input logic [1:0]      mode,
  input logic [1:0]      page_sz,
  input logic [LA_W-1:0] la,
  input logic [PA_W-1:0] pa,
  input logic            hit,
  input logic            abort
);
  logic [PA_W-1:0] omask;
  assign omask = (PA_W'(1) << (MIN_OFF + int'(page_sz))) - PA_W'(1);

  assert_idle_no_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req |-> !abort);
  assert_miss_aborts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !hit) |-> abort);
  assert_super_passes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req && hit && mode[1]) |-> !abort);
  assert_os_read_passes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req && hit && mode == 2'd1 && !wr) |-> !abort);
  assert_offset_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (((pa ^ PA_W'(la)) & omask) == '0));
  assert_empty_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !hit);
endmodule

bind inv_page_xlate inv_page_xlate_chk #(
  .ENTRIES(ENTRIES), .LPN_W(LPN_W), .MIN_OFF(MIN_OFF)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .mode(mode),
  .page_sz(page_sz), .la(la), .pa(pa), .hit(hit), .abort(abort)
);

// File: tb/inv_page_xlate_bench.sv
module inv_page_xlate_bench;
  localparam int ENTRIES = 8;
  localparam int LPN_W   = 5;
  localparam int MIN_OFF = 2;
  localparam int IDX_W   = $clog2(ENTRIES);
  localparam int LA_W    = LPN_W + MIN_OFF;
  localparam int PA_W    = IDX_W + MIN_OFF + 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, wr = 1'b0, wen = 1'b0;
  logic [1:0] mode = '0, page_sz = '0, wprot = '0;
  logic [LA_W-1:0] la = '0;
  logic [IDX_W-1:0] widx = '0;
  logic [LPN_W-1:0] wlpn = '0;
  logic [PA_W-1:0] pa;
  logic hit, abort;

  int checks = 0, fails = 0;
  bit done = 0;
  bit m_vld [ENTRIES];
  int m_lpn [ENTRIES];
  int m_prot[ENTRIES];

  always #4 clk = ~clk;

  inv_page_xlate #(.ENTRIES(ENTRIES), .LPN_W(LPN_W), .MIN_OFF(MIN_OFF)) u_inv_page_xlate (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .mode(mode), .page_sz(page_sz),
    .la(la), .wen(wen), .widx(widx), .wlpn(wlpn), .wprot(wprot),
    .pa(pa), .hit(hit), .abort(abort));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (la=%0d ps=%0d mode=%0d wr=%0d)",
               tag, act, exp, la, page_sz, mode, wr);
    end
  endtask

  task automatic load(int idx, int lp, int pr);
    @(negedge clk);
    wen = 1'b1; widx = IDX_W'(idx); wlpn = LPN_W'(lp); wprot = 2'(pr);
    @(negedge clk);
    wen = 1'b0;
    m_vld[idx] = 1; m_lpn[idx] = lp; m_prot[idx] = pr;
  endtask

  task automatic sweep(string hit_tag, bit rq);
    for (int ps = 0; ps < 4; ps++)
      for (int a = 0; a < (1 << LA_W); a++)
        for (int md = 0; md < 4; md++)
          for (int w = 0; w < 2; w++) begin
            int sh, pg, idx, lv, epa;
            bit ok, eab;
            string atag;
            @(negedge clk);
            req = rq; wr = w[0]; mode = 2'(md); page_sz = 2'(ps); la = LA_W'(a);
            #1;
            sh = MIN_OFF + ps; pg = a >> sh; idx = -1;
            for (int i = ENTRIES - 1; i >= 0; i--)
              if (m_vld[i] && m_lpn[i] == pg) idx = i;
            lv = (idx >= 0) ? m_prot[idx] : 0;
            if (md >= 2) ok = 1;
            else if (md == 1) ok = (lv < 2) || (w == 0);
            else ok = (lv == 0) || (lv == 1 && w == 0);
            epa = (idx >= 0) ? ((idx << sh) | (a & ((1 << sh) - 1))) : 0;
            eab = rq && (idx < 0 || !ok);
            if (!rq) atag = "R10";
            else if (idx < 0) atag = "R5";
            else if (md >= 2) atag = "R6";
            else if (md == 1) atag = "R8";
            else atag = "R7";
            chk(hit_tag, int'(hit), int'(idx >= 0));
            chk((idx >= 0) ? "R3" : "R5", int'(pa), epa);
            chk(atag, int'(abort), int'(eab));
          end
  endtask

  initial begin
    for (int i = 0; i < ENTRIES; i++) begin m_vld[i] = 0; m_lpn[i] = 0; m_prot[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    sweep("R1", 1'b1);
    load(0, 2, 0);
    load(1, 3, 1);
    load(5, 3, 3);
    load(3, 7, 2);
    load(6, 1, 3);
    load(7, 0, 1);
    load(2, 3, 2);
    sweep("R2", 1'b1);
    load(1, 9, 0);
    load(4, 3, 0);
    sweep("R4", 1'b1);
    load(2, 31, 1);
    load(0, 12, 3);
    sweep("R9", 1'b0);
    sweep("R9", 1'b1);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 190000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule